// File: doc/BRIEF.md
# Relaxation-Oscillator Touch Sense Counter

This block measures an external capacitance by repeated relaxation cycles on one sense pad. In each cycle it drives the pad low to discharge the capacitor, then releases the pad and counts clock cycles until a comparator watching the pad voltage reports that the capacitor has charged past its threshold. The counts from a programmable number of cycles are added into one 24-bit total. When the last cycle ends, an interrupt is raised. A larger capacitance, such as a finger on the pad, gives a longer charge time and a larger total.

In its second mode the pad is not used for sensing. Instead it carries a reference clock, divided down from the block clock by a programmable ratio. Software selects the mode, sets the discharge time, the cycle count and the divider, then raises the enable. The comparator passes through a synchronizer inside the block. The analog comparator and the register interface sit outside the block.

Top module: `touch_relax_counter`

## Requirements
- R1: `lowTimeSel` codes 0, 1, 2 and 3 hold the pad driven low (`padOe`=1, `padOut`=0) for 1, 2, 8 and 16 consecutive clock cycles in each relaxation cycle.
- R2: After each discharge the pad is released (`padOe`=0). Every released cycle adds one to `count` until the comparator, delayed by a two-flop synchronizer, is seen high. The comparator is ignored in the first two released cycles. The next discharge starts in the cycle after the one that sees it high. While `enable`=1 and `clrCount`=0, `count` never decreases.
- R3: After 2^`cycleExp` relaxation cycles the sequence stops, `count` holds its total and, if `irqEnable`=1, `irq` rises.
- R4: While `clrCount`=1, `count` reads 0 from the next clock edge. Relaxation cycles keep running, and counting resumes when `clrCount` returns to 0.
- R5: `irqEnable`=0 forces `irq` to 0 at the next edge and clears the pending event, so that raising `irqEnable` again does not bring `irq` back.
- R6: `enable`=0 clears `count` and `irq` and releases the pad at the next edge. The mode is taken from `refClkMode` when `enable` rises.
- R7: In reference-clock mode `padOe`=1 and `padOut` toggles every `clkDiv`+1 cycles, giving a period of 2×(`clkDiv`+1) cycles. `count` and `irq` stay 0 in this mode.
- R8: `count` saturates at all ones and does not wrap.
- R9: Once raised, `irq` stays high until `irqEnable` or `enable` is cleared.
- R10: After `rstN` is released with `enable`=0, `count`=0, `irq`=0 and `padOe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the block; 0 holds it cleared |
| refClkMode | input | 1 | 0 sense mode, 1 reference-clock mode |
| lowTimeSel | input | 2 | Discharge time code |
| cycleExp | input | 3 | Log2 of the relaxation cycle count |
| clkDiv | input | 8 | Reference clock divider |
| clrCount | input | 1 | Holds the total at zero |
| irqEnable | input | 1 | Interrupt enable; 0 also clears it |
| cmpIn | input | 1 | Asynchronous comparator output |
| padOe | output | 1 | Pad output enable |
| padOut | output | 1 | Pad output value |
| count | output | 24 | Accumulated count |
| irq | output | 1 | Completion interrupt |

## Verification
The bench uses a comparator model that rises a fixed number of cycles after the pad is released. This tests how the synchronizer delay and the blanking window add up. A design that lost one flop or miscounted the blanking would be off by one per cycle, multiplied by up to 128 cycles. Every discharge pulse is timed, and the pulses are counted. A wrong discharge-code mapping or an off-by-one in the power-of-two loop would show there. A narrow copy of the block, run with a comparator that never fires, shows whether the total wraps to a small value instead of saturating. The interrupt is cleared and then re-enabled, which catches a design that only masks it. The divider is checked at both its smallest and a mid setting for half-period length.

// File: rtl/touch_relax_pkg.sv
package touch_relax_pkg;

  localparam int LOW_W = 5;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LOW,
    ST_MEAS,
    ST_DONE,
    ST_REF
  } relaxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic lowRun;
    logic measRun;
    logic accumEn;
    logic cycleDone;
    logic setIrq;
    logic refRun;
  } relaxStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic lowDone;
    logic blankDone;
    logic cmpHigh;
    logic lastCycle;
  } relaxStatus_t;

  function automatic logic [LOW_W-1:0] lowLimit(input logic [1:0] code);
    case (code)
      2'd0:    return LOW_W'(1);
      2'd1:    return LOW_W'(2);
      2'd2:    return LOW_W'(8);
      default: return LOW_W'(16);
    endcase
  endfunction

endpackage

// File: rtl/touch_relax_ctrl.sv
module touch_relax_ctrl
  import touch_relax_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         refClkMode,
  input  relaxStatus_t status,
  output relaxStrobe_t strobe
);

  relaxState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!enable) begin
      strobe.clearAll = 1'b1;
      stateNext       = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          stateNext = refClkMode ? ST_REF : ST_LOW;
        end
        ST_LOW: begin
          strobe.lowRun = 1'b1;
          if (status.lowDone) stateNext = ST_MEAS;
        end
        ST_MEAS: begin
          strobe.measRun = 1'b1;
          if (status.blankDone && status.cmpHigh) begin
            strobe.cycleDone = 1'b1;
            if (status.lastCycle) begin
              strobe.setIrq = 1'b1;
              stateNext     = ST_DONE;
            end else begin
              stateNext = ST_LOW;
            end
          end else begin
            strobe.accumEn = 1'b1;
          end
        end
        ST_DONE: stateNext = ST_DONE;
        ST_REF: begin
          strobe.refRun = 1'b1;
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/touch_relax_datapath.sv
module touch_relax_datapath
  import touch_relax_pkg::*;
#(
  parameter int COUNT_W     = 24,
  parameter int EXP_W       = 3,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  relaxStrobe_t       strobe,
  input  logic [1:0]         lowTimeSel,
  input  logic [EXP_W-1:0]   cycleExp,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               clrCount,
  input  logic               irqEnable,
  input  logic               cmpIn,
  output relaxStatus_t       status,
  output logic               padOe,
  output logic               padOut,
  output logic [COUNT_W-1:0] count,
  output logic               irq
);

  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CYC_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam int BLANK   = SYNC_STAGES;
  localparam int BLANK_W = $clog2(BLANK + 1);

  // comparator synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= cmpIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], cmpIn};
      end
    end
  endgenerate

  logic [LOW_W-1:0]   lowCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic [CYC_W-1:0]   cycleCnt;
  logic [CYC_W-1:0]   cycleLast;
  logic [DIV_W-1:0]   divCnt;
  logic               refLevel;
  logic [COUNT_W-1:0] accum;
  logic               irqFlag;

  // discharge timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lowCnt <= '0;
    else if (!strobe.lowRun) lowCnt <= '0;
    else                     lowCnt <= lowCnt + 1'b1;
  end

  // blanking window covering the synchronizer delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      blankCnt <= '0;
    else if (!strobe.measRun)       blankCnt <= '0;
    else if (blankCnt < BLANK_W'(BLANK)) blankCnt <= blankCnt + 1'b1;
  end

  // relaxation cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cycleCnt <= '0;
    else if (strobe.clearAll)  cycleCnt <= '0;
    else if (strobe.cycleDone) cycleCnt <= cycleCnt + 1'b1;
  end

  assign cycleLast = {CYC_W{1'b1}} >> (MAX_EXP - int'(cycleExp));

  // saturating accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           accum <= '0;
    else if (strobe.clearAll || clrCount) accum <= '0;
    else if (strobe.accumEn && (accum != {COUNT_W{1'b1}}))
      accum <= accum + 1'b1;
  end

  // reference clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      refLevel <= 1'b0;
    end else if (!strobe.refRun) begin
      divCnt   <= '0;
      refLevel <= 1'b0;
    end else if (divCnt == clkDiv) begin
      divCnt   <= '0;
      refLevel <= ~refLevel;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // sticky interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             irqFlag <= 1'b0;
    else if (strobe.clearAll || !irqEnable) irqFlag <= 1'b0;
    else if (strobe.setIrq)                 irqFlag <= 1'b1;
  end

  always_comb begin
    status.lowDone   = (lowCnt == (lowLimit(lowTimeSel) - 1'b1));
    status.blankDone = (blankCnt >= BLANK_W'(BLANK));
    status.cmpHigh   = syncChain[SYNC_STAGES-1];
    status.lastCycle = (cycleCnt == cycleLast);
  end

  assign padOe  = strobe.lowRun | strobe.refRun;
  assign padOut = strobe.refRun & refLevel;
  assign count  = accum;
  assign irq    = irqFlag;

endmodule

// File: rtl/touch_relax_counter.sv
module touch_relax_counter
  import touch_relax_pkg::*;
#(
  parameter int COUNT_W = 24,
  parameter int EXP_W   = 3,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               refClkMode,
  input  logic [1:0]         lowTimeSel,
  input  logic [EXP_W-1:0]   cycleExp,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               clrCount,
  input  logic               irqEnable,
  input  logic               cmpIn,
  output logic               padOe,
  output logic               padOut,
  output logic [COUNT_W-1:0] count,
  output logic               irq
);

  relaxStrobe_t strobe;
  relaxStatus_t status;

  touch_relax_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .refClkMode (refClkMode),
    .status     (status),
    .strobe     (strobe)
  );

  touch_relax_datapath #(
    .COUNT_W     (COUNT_W),
    .EXP_W       (EXP_W),
    .DIV_W       (DIV_W),
    .SYNC_STAGES (2)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lowTimeSel (lowTimeSel),
    .cycleExp   (cycleExp),
    .clkDiv     (clkDiv),
    .clrCount   (clrCount),
    .irqEnable  (irqEnable),
    .cmpIn      (cmpIn),
    .status     (status),
    .padOe      (padOe),
    .padOut     (padOut),
    .count      (count),
    .irq        (irq)
  );

endmodule

// File: rtl/touch_relax_checker.sv
module touch_relax_checker #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               clrCount,
  input logic               irqEnable,
  input logic               padOe,
  input logic [COUNT_W-1:0] count,
  input logic               irq
);

  p_off_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!padOe && (count == '0) && !irq));

  p_irq_cleared_r5: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |=> !irq);

  p_count_zeroed_r4: assert property (@(posedge clk) disable iff (!rstN)
    clrCount |=> (count == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !clrCount && (count == {COUNT_W{1'b1}})) |=> (count == {COUNT_W{1'b1}}));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && enable && irqEnable) |=> irq);

  p_monotonic_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !clrCount) |=> (count >= $past(count)));

endmodule

bind touch_relax_counter touch_relax_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .clrCount  (clrCount),
  .irqEnable (irqEnable),
  .padOe     (padOe),
  .count     (count),
  .irq       (irq)
);

// File: tb/touch_relax_counter_tb.sv
module touch_relax_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        refClkMode = 1'b0;
  logic [1:0]  lowTimeSel = '0;
  logic [2:0]  cycleExp = '0;
  logic [7:0]  clkDiv = '0;
  logic        clrCount = 1'b0;
  logic        irqEnable = 1'b0;
  logic        cmpIn = 1'b0;
  logic        padOe, padOut, irq;
  logic [23:0] count;

  // narrow copy for the saturation test, comparator never fires
  logic        satEnable = 1'b0;
  logic        satPadOe, satPadOut, satIrq;
  logic [7:0]  satCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  touch_relax_counter u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .refClkMode(refClkMode),
    .lowTimeSel(lowTimeSel), .cycleExp(cycleExp), .clkDiv(clkDiv),
    .clrCount(clrCount), .irqEnable(irqEnable), .cmpIn(cmpIn),
    .padOe(padOe), .padOut(padOut), .count(count), .irq(irq)
  );

  touch_relax_counter #(.COUNT_W(8)) u_dutSat (
    .clk(clk), .rstN(rstN), .enable(satEnable), .refClkMode(1'b0),
    .lowTimeSel(2'd0), .cycleExp(3'd7), .clkDiv(8'd0),
    .clrCount(1'b0), .irqEnable(1'b1), .cmpIn(1'b0),
    .padOe(satPadOe), .padOut(satPadOut), .count(satCount), .irq(satIrq)
  );

  // vector: {lowTimeSel, cycleExp, riseDelay, expected count}
  localparam int NVEC = 8;
  localparam logic [36:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 8'd1,  24'd2},
    {2'd1, 3'd1, 8'd3,  24'd8},
    {2'd2, 3'd2, 8'd5,  24'd24},
    {2'd3, 3'd3, 8'd2,  24'd24},
    {2'd0, 3'd4, 8'd7,  24'd128},
    {2'd2, 3'd7, 8'd1,  24'd256},
    {2'd1, 3'd5, 8'd10, 24'd352},
    {2'd3, 3'd6, 8'd4,  24'd320}
  };

  // comparator model and discharge pulse monitor
  int  riseDelay = 1;
  int  relCnt = 0;
  int  lowRun = 0;
  int  expLow = 1;
  int  pulses = 0;
  int  badPulses = 0;
  bit  monOn = 0;

  always @(negedge clk) begin
    if (padOe) relCnt = 0;
    else if (relCnt < 100000) relCnt = relCnt + 1;
    cmpIn <= (!padOe && relCnt >= riseDelay);
    if (monOn) begin
      if (padOe && !padOut) lowRun = lowRun + 1;
      else if (lowRun != 0) begin
        if (lowRun != expLow) badPulses = badPulses + 1;
        pulses = pulses + 1;
        lowRun = 0;
      end
    end
  end

  function automatic int lowWidth(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitIrq(output bit seen);
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
  endtask

  task automatic measureRef(output int hiLen, output int loLen);
    hiLen = 0; loLen = 0;
    for (int i = 0; i < 2000 && padOut; i++) @(negedge clk);
    for (int i = 0; i < 2000 && !padOut; i++) @(negedge clk);
    while (padOut && hiLen < 2000) begin hiLen++; @(negedge clk); end
    while (!padOut && loLen < 2000) begin loLen++; @(negedge clk); end
  endtask

  initial begin
    #(20ns * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    int hiLen, loLen;
    logic [23:0] held;

    tick(3);
    rstN = 1'b1;
    tick(2);
    // R10 reset state
    check(count == 0, "R10 count", count, 0);
    check(!irq, "R10 irq", irq, 0);
    check(!padOe, "R10 padOe", padOe, 0);

    // table of sense-mode vectors: R1, R2, R3
    irqEnable = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      enable = 1'b0;
      tick(4);
      lowTimeSel = VEC[v][36:35];
      cycleExp   = VEC[v][34:32];
      riseDelay  = int'(VEC[v][31:24]);
      expLow     = lowWidth(VEC[v][36:35]);
      pulses = 0; badPulses = 0; lowRun = 0;
      monOn = 1;
      enable = 1'b1;
      waitIrq(seen);
      check(seen, "R3 irq raised", seen, 1);
      check(count == VEC[v][23:0], "R2 count total", count, VEC[v][23:0]);
      check(pulses == (1 << VEC[v][34:32]), "R3 cycle count", pulses, 1 << VEC[v][34:32]);
      check(badPulses == 0, "R1 low width", badPulses, 0);
      monOn = 0;
    end

    // R9 irq and count held after completion
    held = count;
    tick(30);
    check(irq, "R9 irq held", irq, 1);
    check(count == held, "R3 count held", count, held);

    // R5 clearing irqEnable clears, not just masks
    irqEnable = 1'b0;
    tick(1);
    check(!irq, "R5 irq cleared", irq, 0);
    irqEnable = 1'b1;
    tick(3);
    check(!irq, "R5 irq stays clear", irq, 0);

    // R4 clear during a run, then release
    enable = 1'b0;
    tick(4);
    lowTimeSel = 2'd0; cycleExp = 3'd7; riseDelay = 3;
    enable = 1'b1;
    tick(40);
    clrCount = 1'b1;
    tick(1);
    check(count == 0, "R4 cleared", count, 0);
    tick(40);
    check(count == 0, "R4 held at zero", count, 0);
    clrCount = 1'b0;
    tick(40);
    check(count > 0, "R4 resumes", count, 1);

    // R6 enable drop mid-run
    enable = 1'b0;
    tick(1);
    check(count == 0, "R6 count", count, 0);
    check(!padOe, "R6 pad released", padOe, 0);
    check(!irq, "R6 irq", irq, 0);

    // R7 reference clock mode
    refClkMode = 1'b1; clkDiv = 8'd3;
    tick(2);
    enable = 1'b1;
    tick(3);
    check(padOe, "R7 pad driven", padOe, 1);
    measureRef(hiLen, loLen);
    check(hiLen == 4, "R7 high time div3", hiLen, 4);
    check(loLen == 4, "R7 low time div3", loLen, 4);
    clkDiv = 8'd0;
    tick(10);
    measureRef(hiLen, loLen);
    check(hiLen == 1, "R7 high time div0", hiLen, 1);
    check(loLen == 1, "R7 low time div0", loLen, 1);
    check(count == 0 && !irq, "R7 no count or irq", count, 0);
    enable = 1'b0;
    refClkMode = 1'b0;

    // R8 saturation on the narrow copy
    satEnable = 1'b1;
    tick(400);
    check(satCount == 8'hFF, "R8 saturated", satCount, 255);
    tick(50);
    check(satCount == 8'hFF, "R8 no wrap", satCount, 255);
    check(!satIrq, "R8 no irq", satIrq, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule